// File: doc/BRIEF.md
# Scan Chain Test Sequencer

This block wraps a small registered circuit in a multiplexed-D scan chain and runs the complete scan test procedure on it without outside help. After a start request the sequencer first proves the chain is intact. It pushes a run of ones and then a run of zeros through the chain and watches the tail. It then shifts in the first initial state and drives one primary-input pattern. Next it drops the shift mode for a single functional clock so that every flop captures its response. It returns to shift mode to bring that response out, and the next initial state goes in on the same clock edges.

The initial states, primary-input patterns and expected responses come from a small table computed inside the block. The first observed difference raises a sticky failure flag and records the number of the pattern that caused it. A broken chain is reported with an index one past the last pattern. A one-cycle completion pulse closes every run. A fault variant can be chosen by parameter so that a stuck functional input or a stuck shift path can be built on purpose.

Top module: `scan_seq_top`

## Requirements
- R1: While reset is asserted and right after it, scan_en, done, fail, fail_idx and pi are all zero.
- R2: Outside a run, scan_en is low. A start pulse is accepted only while no run is in progress, and a start pulse during a run changes nothing.
- R3: The chain has N edge-triggered flops, each with a 2:1 multiplexer on its D input. With scan_en high, bit 0 takes scan_in, bit i takes bit i-1, and scan_out is bit N-1. With scan_en low, the chain loads the circuit's next state: bit i takes state[i-1] xor pi[i], and bit 0 takes state[N-1] xor pi[0].
- R4: After start, the block shifts for 2N cycles with scan_in=1 and then for 2N cycles with scan_in=0. In the last N cycles of each run, scan_out must equal the flushed constant. On a mismatch, fail is set with fail_idx = NPAT.
- R5: The block then shifts for N cycles to load the initial state of pattern 0, most significant bit first.
- R6: Each pattern gets exactly one capture cycle. In that cycle scan_en is low and pi carries the pattern's input word. In every other cycle pi is zero.
- R7: After each capture the block shifts for N cycles. scan_out is compared, most significant bit first, with the expected response. scan_in carries the next pattern's initial state in the same cycles, or zeros after the last pattern.
- R8: Only the first mismatch sets fail and fail_idx (the pattern number). Both hold until the next accepted start clears them.
- R9: One cycle after the last unload, done is high for exactly one cycle with scan_en low, and the block returns to idle.
- R10: For pattern k, let h = ((k+1) * 0x9E3779B1) mod 2^32. The initial state is h[N-1:0], the input word is h[16+N-1:16], and the expected response is the initial state rotated left by one, xor the input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for chain and sequencer |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a test run |
| scan_en | output | 1 | Shift mode select for the chain |
| scan_in | output | 1 | Serial bit fed into chain bit 0 |
| scan_out | output | 1 | Serial bit leaving chain bit N-1 |
| pi | output | N | Primary-input word applied to the circuit |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky mismatch flag |
| fail_idx | output | $clog2(NPAT+1) | Pattern number of the first mismatch |

## Verification
The bench builds three copies with N=8 and NPAT=6. The first is fault-free and is compared every cycle against a behavioural model on every output. The second has bit 3's functional input stuck at 0. Its first failing response is pattern 1, not pattern 0, so the recorded index cannot pass by defaulting to zero. The third has bit 5's shift path stuck at 1. The ones flush passes but the zeros flush fails, which exercises the chain-integrity index of NPAT and the ordering of the two flushes.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_FL1,
      PH_FL0,
      PH_LOAD,
      PH_CAPT,
      PH_SHIFT,
      PH_DONE
   } phase_t;

   // Pattern seed word for pattern number k (R10)
   function automatic logic [31:0] pat_hash(input logic [31:0] k);
      return (k + 32'd1) * 32'h9E3779B1;
   endfunction

endpackage

// File: rtl/scan_cut_logic.sv
module scan_cut_logic #(
   parameter int N = 8
) (
   input  logic [N-1:0] state,
   input  logic [N-1:0] pi,
   output logic [N-1:0] nxt
);
   // Next state: rotate left by one, then mix in the primary inputs
   assign nxt = {state[N-2:0], state[N-1]} ^ pi;
endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
   parameter int N        = 8,
   parameter int FLT_KIND = 0,
   parameter int FLT_BIT  = 0,
   parameter bit FLT_VAL  = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         scan_en,
   input  logic         scan_in,
   input  logic [N-1:0] func_d,
   output logic [N-1:0] q,
   output logic         scan_out
);
   localparam int KIND_FUNC = 1;
   localparam int KIND_SHIFT = 2;

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic sh_src;
      logic fn_src;
      logic d;
      logic flop;

      if (i == 0) begin : g_head
         assign sh_src = scan_in;
      end else begin : g_link
         assign sh_src = q[i-1];
      end

      if (FLT_KIND == KIND_FUNC && i == FLT_BIT) begin : g_fn_stuck
         assign fn_src = FLT_VAL;
      end else begin : g_fn
         assign fn_src = func_d[i];
      end

      if (FLT_KIND == KIND_SHIFT && i == FLT_BIT) begin : g_sh_stuck
         assign d = scan_en ? (FLT_VAL | (sh_src & FLT_VAL)) : fn_src;
      end else begin : g_mux
         assign d = scan_en ? sh_src : fn_src;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flop <= 1'b0;
         else        flop <= d;
      end

      assign q[i] = flop;
   end

   assign scan_out = q[N-1];
endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
   import scan_seq_pkg::*;
#(
   parameter int N    = 8,
   parameter int NPAT = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      scan_out,
   output logic                      scan_en,
   output logic                      scan_in,
   output logic [N-1:0]              pi,
   output logic                      done,
   output logic                      fail,
   output logic [$clog2(NPAT+1)-1:0] fail_idx
);
   localparam int CW = $clog2(2*N);
   localparam int LW = $clog2(N);
   localparam int KW = (NPAT > 1) ? $clog2(NPAT) : 1;
   localparam int IW = $clog2(NPAT+1);

   phase_t          ph;
   logic [CW-1:0]   cnt;
   logic [KW-1:0]   k;
   logic [LW-1:0]   bpos;
   logic [N-1:0]    s_first, s_cur, s_nxt, p_cur, e_cur;
   logic            last_pat, in_flush, fill_done, flush_bad, resp_bad;

   assign s_first  = N'(pat_hash(32'd0));
   assign s_cur    = N'(pat_hash(32'(k)));
   assign p_cur    = N'(pat_hash(32'(k)) >> 16);
   assign s_nxt    = N'(pat_hash(32'(k) + 32'd1));
   assign e_cur    = {s_cur[N-2:0], s_cur[N-1]} ^ p_cur;

   assign bpos      = LW'(N-1) - LW'(cnt);
   assign last_pat  = (k == KW'(NPAT-1));
   assign in_flush  = (ph == PH_FL1) || (ph == PH_FL0);
   assign fill_done = (cnt >= CW'(N));
   assign flush_bad = in_flush && fill_done && (scan_out != (ph == PH_FL1));
   assign resp_bad  = (ph == PH_SHIFT) && (scan_out != e_cur[bpos]);

   assign scan_en = (ph == PH_FL1) || (ph == PH_FL0) ||
                    (ph == PH_LOAD) || (ph == PH_SHIFT);
   assign done    = (ph == PH_DONE);
   assign pi      = (ph == PH_CAPT) ? p_cur : '0;

   always_comb begin
      case (ph)
         PH_FL1:   scan_in = 1'b1;
         PH_LOAD:  scan_in = s_first[bpos];
         PH_SHIFT: scan_in = last_pat ? 1'b0 : s_nxt[bpos];
         default:  scan_in = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= PH_IDLE;
         cnt      <= '0;
         k        <= '0;
         fail     <= 1'b0;
         fail_idx <= '0;
      end else begin
         case (ph)
            PH_IDLE: if (start) begin
               ph       <= PH_FL1;
               cnt      <= '0;
               fail     <= 1'b0;
               fail_idx <= '0;
            end
            PH_FL1, PH_FL0: begin
               if (cnt == CW'(2*N-1)) begin
                  ph  <= (ph == PH_FL1) ? PH_FL0 : PH_LOAD;
                  cnt <= '0;
               end else cnt <= cnt + 1'b1;
            end
            PH_LOAD: begin
               if (cnt == CW'(N-1)) begin
                  ph  <= PH_CAPT;
                  cnt <= '0;
                  k   <= '0;
               end else cnt <= cnt + 1'b1;
            end
            PH_CAPT: begin
               ph  <= PH_SHIFT;
               cnt <= '0;
            end
            PH_SHIFT: begin
               if (cnt == CW'(N-1)) begin
                  cnt <= '0;
                  if (last_pat) ph <= PH_DONE;
                  else begin
                     ph <= PH_CAPT;
                     k  <= k + 1'b1;
                  end
               end else cnt <= cnt + 1'b1;
            end
            default: ph <= PH_IDLE;
         endcase
         if (!fail && (flush_bad || resp_bad)) begin
            fail     <= 1'b1;
            fail_idx <= flush_bad ? IW'(NPAT) : IW'(k);
         end
      end
   end
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top #(
   parameter int N        = 8,
   parameter int NPAT     = 6,
   parameter int FLT_KIND = 0,
   parameter int FLT_BIT  = 0,
   parameter bit FLT_VAL  = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   output logic                      scan_en,
   output logic                      scan_in,
   output logic                      scan_out,
   output logic [N-1:0]              pi,
   output logic                      done,
   output logic                      fail,
   output logic [$clog2(NPAT+1)-1:0] fail_idx
);
   if (N < 2 || N > 16) begin : g_bad_n
      $error("scan_seq_top: N must lie in 2..16");
   end
   if (NPAT < 1) begin : g_bad_npat
      $error("scan_seq_top: NPAT must be at least 1");
   end
   if (FLT_KIND < 0 || FLT_KIND > 2 || FLT_BIT < 0 || FLT_BIT >= N) begin : g_bad_flt
      $error("scan_seq_top: fault selection out of range");
   end

   logic [N-1:0] chain_q;
   logic [N-1:0] func_d;

   scan_seq_ctrl #(.N(N), .NPAT(NPAT)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .scan_out (scan_out),
      .scan_en  (scan_en),
      .scan_in  (scan_in),
      .pi       (pi),
      .done     (done),
      .fail     (fail),
      .fail_idx (fail_idx)
   );

   scan_cut_logic #(.N(N)) u_cut (
      .state (chain_q),
      .pi    (pi),
      .nxt   (func_d)
   );

   scan_chain #(
      .N(N), .FLT_KIND(FLT_KIND), .FLT_BIT(FLT_BIT), .FLT_VAL(FLT_VAL)
   ) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .scan_en  (scan_en),
      .scan_in  (scan_in),
      .func_d   (func_d),
      .q        (chain_q),
      .scan_out (scan_out)
   );
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
   parameter int N    = 8,
   parameter int NPAT = 6,
   parameter int IW   = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          scan_en,
   input logic [N-1:0]  pi,
   input logic          done,
   input logic          fail,
   input logic [IW-1:0] fail_idx
);
   AST_DONE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !scan_en); // R9
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_CAPTURE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(scan_en) && !done) |=> scan_en); // R6
   AST_PI_ONLY_IN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (pi != '0) |-> !scan_en); // R6
   AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !start) |=> fail); // R8
   AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !start) |=> $stable(fail_idx)); // R8
   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> (fail_idx <= IW'(NPAT))); // R4
endmodule

bind scan_seq_top scan_seq_chk #(
   .N(N), .NPAT(NPAT), .IW($clog2(NPAT+1))
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .scan_en(scan_en),
   .pi(pi), .done(done), .fail(fail), .fail_idx(fail_idx)
);

// File: tb/test_scan_seq_top.sv
module test_scan_seq_top;
   localparam int N  = 8;
   localparam int NP = 6;
   localparam int IW = $clog2(NP+1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   always #5 clk = ~clk;

   logic          se, si, so, dn, fl;
   logic [N-1:0]  piw;
   logic [IW-1:0] fx;
   logic          se_a, si_a, so_a, dn_a, fl_a;
   logic [N-1:0]  pi_a;
   logic [IW-1:0] fx_a;
   logic          se_b, si_b, so_b, dn_b, fl_b;
   logic [N-1:0]  pi_b;
   logic [IW-1:0] fx_b;

   scan_seq_top #(.N(N), .NPAT(NP)) i_scan_seq_top (
      .clk(clk), .rst_n(rst_n), .start(start), .scan_en(se), .scan_in(si),
      .scan_out(so), .pi(piw), .done(dn), .fail(fl), .fail_idx(fx));

   // functional input of bit 3 stuck at 0
   scan_seq_top #(.N(N), .NPAT(NP), .FLT_KIND(1), .FLT_BIT(3), .FLT_VAL(1'b0)) i_fn_fault (
      .clk(clk), .rst_n(rst_n), .start(start), .scan_en(se_a), .scan_in(si_a),
      .scan_out(so_a), .pi(pi_a), .done(dn_a), .fail(fl_a), .fail_idx(fx_a));

   // shift path into bit 5 stuck at 1
   scan_seq_top #(.N(N), .NPAT(NP), .FLT_KIND(2), .FLT_BIT(5), .FLT_VAL(1'b1)) i_sh_fault (
      .clk(clk), .rst_n(rst_n), .start(start), .scan_en(se_b), .scan_in(si_b),
      .scan_out(so_b), .pi(pi_b), .done(dn_b), .fail(fl_b), .fail_idx(fx_b));

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // R10 pattern formula
   function automatic logic [31:0] hsh(input int k);
      return 32'(k + 1) * 32'h9E3779B1;
   endfunction
   function automatic logic [N-1:0] st(input int k);
      logic [31:0] h = hsh(k);
      return h[N-1:0];
   endfunction
   function automatic logic [N-1:0] pv(input int k);
      logic [31:0] h = hsh(k);
      return h[16+N-1:16];
   endfunction
   function automatic logic [N-1:0] rs(input int k);
      logic [N-1:0] s = st(k);
      return {s[N-2:0], s[N-1]} ^ pv(k);
   endfunction

   // behavioural reference: 0 idle,1 ones,2 zeros,3 load,4 capture,5 shift,6 done
   int           m_ph = 0, m_cnt = 0, m_k = 0, m_idx = 0;
   logic         m_fail = 1'b0;
   logic [N-1:0] m_chain = '0;

   function automatic logic x_se();
      return (m_ph == 1 || m_ph == 2 || m_ph == 3 || m_ph == 5);
   endfunction
   function automatic logic x_si();
      logic [N-1:0] v;
      case (m_ph)
         1: return 1'b1;
         3: begin v = st(0); return v[N-1-m_cnt]; end
         5: begin
            if (m_k == NP-1) return 1'b0;
            v = st(m_k + 1);
            return v[N-1-m_cnt];
         end
         default: return 1'b0;
      endcase
   endfunction
   function automatic logic [N-1:0] x_pi();
      return (m_ph == 4) ? pv(m_k) : '0;
   endfunction
   function automatic string tag();
      case (m_ph)
         0: return "R2";
         1, 2: return "R4";
         3: return "R5";
         4: return "R6";
         5: return "R7";
         default: return "R9";
      endcase
   endfunction

   always @(posedge clk) begin
      logic         x_en, x_in, x_out;
      logic [N-1:0] x_p, e;
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_k = 0; m_chain = '0; m_fail = 1'b0; m_idx = 0;
      end else begin
         x_en = x_se(); x_in = x_si(); x_p = x_pi(); x_out = m_chain[N-1];
         e = rs(m_k);
         if (!m_fail && (m_ph == 1 || m_ph == 2) && m_cnt >= N && x_out != (m_ph == 1)) begin
            m_fail = 1'b1; m_idx = NP;
         end
         if (!m_fail && m_ph == 5 && x_out != e[N-1-m_cnt]) begin
            m_fail = 1'b1; m_idx = m_k;
         end
         if (x_en) m_chain = {m_chain[N-2:0], x_in};
         else      m_chain = {m_chain[N-2:0], m_chain[N-1]} ^ x_p;
         case (m_ph)
            0: if (start) begin m_ph = 1; m_cnt = 0; m_fail = 1'b0; m_idx = 0; end
            1, 2: if (m_cnt == 2*N-1) begin m_ph = m_ph + 1; m_cnt = 0; end else m_cnt++;
            3: if (m_cnt == N-1) begin m_ph = 4; m_cnt = 0; m_k = 0; end else m_cnt++;
            4: begin m_ph = 5; m_cnt = 0; end
            5: if (m_cnt == N-1) begin
                  m_cnt = 0;
                  if (m_k == NP-1) m_ph = 6;
                  else begin m_ph = 4; m_k++; end
               end else m_cnt++;
            default: m_ph = 0;
         endcase
      end
   end

   // every-cycle comparison of the fault-free copy
   always @(negedge clk) begin
      if (rst_n) begin
         chk(tag(), "scan_en", 32'(se), 32'(x_se()));
         chk(tag(), "scan_in", 32'(si), 32'(x_si()));
         chk("R6", "pi", 32'(piw), 32'(x_pi()));
         chk("R3", "scan_out", 32'(so), 32'(m_chain[N-1]));
         chk("R9", "done", 32'(dn), 32'(m_ph == 6));
         chk("R8", "fail", 32'(fl), 32'(m_fail));
         chk("R8", "fail_idx", 32'(fx), 32'(m_idx));
      end
   end

   int  cyc = 0;
   bit  finished = 1'b0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !finished) begin
         finished = 1'b1;
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   task automatic wait_done();
      int guard = 0;
      while (!dn && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
   endtask

   int  fn_idx;
   bit  fn_hit;

   task automatic check_faults(input string when);
      chk("R8", {"fn fault fail ", when}, 32'(fl_a), 32'(fn_hit));
      chk("R8", {"fn fault idx ", when}, 32'(fx_a), 32'(fn_hit ? fn_idx : 0));
      chk("R9", {"fn fault done ", when}, 32'(dn_a), 32'd1);
      chk("R4", {"shift fault fail ", when}, 32'(fl_b), 32'd1);
      chk("R4", {"shift fault idx ", when}, 32'(fx_b), 32'(NP));
   endtask

   initial begin
      logic [N-1:0] e;
      fn_hit = 1'b0; fn_idx = 0;
      for (int k = 0; k < NP; k++) begin
         e = rs(k);
         if (!fn_hit && e[3] != 1'b0) begin fn_hit = 1'b1; fn_idx = k; end
      end

      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "scan_en", 32'(se), 0);
      chk("R1", "done", 32'(dn), 0);
      chk("R1", "fail", 32'(fl), 0);
      chk("R1", "fail_idx", 32'(fx), 0);
      chk("R1", "pi", 32'(piw), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // run 1, with a start pulse in the middle that must be ignored (R2)
      start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (20) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      wait_done();
      check_faults("run1");
      repeat (4) @(negedge clk);

      // run 2: flags of the faulty copies are cleared on acceptance (R8)
      start = 1'b1; @(negedge clk); start = 1'b0;
      chk("R8", "fn fault fail cleared", 32'(fl_a), 0);
      chk("R8", "shift fault fail cleared", 32'(fl_b), 0);
      wait_done();
      check_faults("run2");
      chk("R9", "done pulse", 32'(dn), 1);
      @(negedge clk);
      chk("R9", "done single", 32'(dn), 0);
      chk("R2", "idle scan_en", 32'(se), 0);
      repeat (3) @(negedge clk);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule